// File: doc/BRIEF.md
# Cross-Domain Call Stack Unit

This unit guards control transfers between protection domains that share one address space. When the pipeline reports a call whose target carries a switch-gate mark, the unit saves a three-word record (the return address, the caller's domain ID and the caller's frame base) onto a call stack in memory. Only this hardware writes that stack. The unit then moves the current domain to the gate's destination and takes the current stack pointer as the new frame base. When the pipeline reports a return whose instruction carries a return-gate mark, the unit reads the newest record back and compares the saved return address with the actual return target. If they agree, it restores the caller's domain and frame base. A return with no record, a return that lands anywhere other than right after the originating call, and a call with no room left for a record all raise a fault with a code.

The unit owns the domain-ID register, the frame-base register and the top-of-stack register. While a record is being moved over its single-word memory port, it holds `busy` high so that the pipeline stalls. Software can reload the top-of-stack register on a context switch, but only while the current domain is 0.

Top module: `xdc_call_unit`

## Requirements
- R1: After reset, the domain ID is 0, the frame base is 0, the top-of-stack equals `STACK_BASE`, and `busy`, `done` and `fault` are low.
- R2: An accepted gated call writes three 32-bit words. The return address goes to tos-4, the caller's domain ID (zero-extended) to tos-8, and the caller's frame base to tos-12. The top-of-stack then drops by 12, so the stack grows downward.
- R3: A completed gated call sets the domain ID to `call_dest_pd` and the frame base to `call_sp`, and pulses `done` with `fault` low.
- R4: A gated return reads the record at tos (frame base), tos+4 (domain ID) and tos+8 (return address). If the saved return address equals `ret_target`, it restores the domain ID and frame base and raises the top-of-stack by 12.
- R5: A gated return while the top-of-stack is at or above `STACK_BASE` pulses `done` and `fault` with code 1 (empty). It reads no memory, and the domain ID, frame base and top-of-stack stay unchanged.
- R6: A gated return whose saved return address differs from `ret_target` pulses `fault` with code 2 (mismatch). The domain ID, frame base and top-of-stack stay unchanged.
- R7: A gated call while the top-of-stack is below `STACK_LIMIT`+12 pulses `fault` with code 3 (overflow). It writes no memory, and the domain ID, frame base and top-of-stack stay unchanged.
- R8: `busy` rises the cycle after a call or return is accepted and stays high until `done`. Requests presented while `busy` is high are ignored.
- R9: `tos_ld_en` replaces the top-of-stack with `tos_ld_data` only while the domain ID is 0 and the unit is idle. Otherwise it has no effect.
- R10: `user_mode` equals the most significant bit of the domain ID (1 = user, 0 = kernel), and `all_access` is high exactly when the domain ID is 0.

Code 0 on `fault_code` means no fault.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| xcall_req | input | 1 | A call whose target has a switch gate |
| call_dest_pd | input | PD_W | Destination domain of the gate |
| call_ret_addr | input | ADDR_W | Address of the instruction following the call |
| call_sp | input | ADDR_W | Stack pointer at the call, which becomes the new frame base |
| xret_req | input | 1 | A return carrying a return gate |
| ret_target | input | ADDR_W | Address the return would jump to |
| tos_ld_en | input | 1 | Privileged top-of-stack load request |
| tos_ld_data | input | ADDR_W | Value to load into the top-of-stack |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Write enable for the memory access |
| mem_addr | output | ADDR_W | Byte address of the word |
| mem_wdata | output | ADDR_W | Write data |
| mem_rdata | input | ADDR_W | Read data, valid the cycle after a read request |
| busy | output | 1 | Sequence in progress; the pipeline must stall |
| done | output | 1 | One-cycle pulse when a request completes |
| fault | output | 1 | One-cycle pulse with `done` when the request faulted |
| fault_code | output | 2 | 0 none, 1 empty, 2 mismatch, 3 overflow |
| pd_id | output | PD_W | Current protection-domain ID |
| frame_base | output | ADDR_W | Current frame base |
| tos | output | ADDR_W | Current top of the call stack |
| user_mode | output | 1 | Current domain is a user domain |
| all_access | output | 1 | Current domain bypasses permission checks |

## Verification
The mismatch fault is the hardest case to reach. It only arises after a full push has stored a record, and then a later return must present a target different from the stored one. A straight call/return pair never produces it. The stimulus nests two calls, returns once to a wrong address, and confirms that the record is still intact by returning correctly afterwards. The overflow limit is reached by chaining calls until fewer than three words of room remain. The ignore rule for requests while `busy` is high is exercised by pulsing a return in the middle of a push.

// File: rtl/xdc_pkg.sv
package xdc_pkg;
   typedef enum logic [1:0] {
      XF_NONE     = 2'd0,
      XF_EMPTY    = 2'd1,
      XF_MISMATCH = 2'd2,
      XF_OVERFLOW = 2'd3
   } xdc_fault_e;

   typedef enum logic [2:0] {
      SQ_IDLE,
      SQ_PUSH,
      SQ_POP,
      SQ_WAIT,
      SQ_CHECK
   } xdc_seq_e;

   localparam int unsigned REC_WORDS = 3;
   localparam int unsigned WORD_BYTES = 4;
endpackage

// File: rtl/xdc_state.sv
module xdc_state #(
   parameter int unsigned ADDR_W = 32,
   parameter int unsigned PD_W = 16,
   parameter logic [ADDR_W-1:0] STACK_BASE = 32'h0000_0100
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              busy,
   input  logic              ld_en,
   input  logic [ADDR_W-1:0] ld_data,
   input  logic              commit,
   input  logic [PD_W-1:0]   new_pd,
   input  logic [ADDR_W-1:0] new_fb,
   input  logic [ADDR_W-1:0] new_tos,
   output logic [PD_W-1:0]   pd_q,
   output logic [ADDR_W-1:0] fb_q,
   output logic [ADDR_W-1:0] tos_q
);
   logic privileged;
   assign privileged = (pd_q == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pd_q  <= '0;
         fb_q  <= '0;
         tos_q <= STACK_BASE;
      end else if (commit) begin
         pd_q  <= new_pd;
         fb_q  <= new_fb;
         tos_q <= new_tos;
      end else if (ld_en && privileged && !busy) begin
         tos_q <= ld_data;
      end
   end
endmodule

// File: rtl/xdc_seq.sv
module xdc_seq
   import xdc_pkg::*;
#(
   parameter int unsigned ADDR_W = 32,
   parameter int unsigned PD_W = 16,
   parameter logic [ADDR_W-1:0] STACK_BASE = 32'h0000_0100,
   parameter logic [ADDR_W-1:0] STACK_LIMIT = 32'h0000_00C0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              xcall_req,
   input  logic [PD_W-1:0]   call_dest_pd,
   input  logic [ADDR_W-1:0] call_ret_addr,
   input  logic [ADDR_W-1:0] call_sp,
   input  logic              xret_req,
   input  logic [ADDR_W-1:0] ret_target,
   input  logic [PD_W-1:0]   pd_q,
   input  logic [ADDR_W-1:0] fb_q,
   input  logic [ADDR_W-1:0] tos_q,
   output logic              mem_req,
   output logic              mem_we,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [ADDR_W-1:0] mem_wdata,
   input  logic [ADDR_W-1:0] mem_rdata,
   output logic              busy,
   output logic              commit,
   output logic [PD_W-1:0]   new_pd,
   output logic [ADDR_W-1:0] new_fb,
   output logic [ADDR_W-1:0] new_tos,
   output logic              done_q,
   output logic              fault_q,
   output xdc_fault_e        code_q
);
   localparam logic [ADDR_W-1:0] STEP      = ADDR_W'(WORD_BYTES);
   localparam logic [ADDR_W-1:0] REC_BYTES = ADDR_W'(REC_WORDS * WORD_BYTES);
   localparam logic [ADDR_W-1:0] FULL_MARK = STACK_LIMIT + REC_BYTES;
   localparam int unsigned       CNT_W     = $clog2(REC_WORDS);
   localparam logic [CNT_W-1:0]  LAST      = CNT_W'(REC_WORDS - 1);
   localparam int unsigned       SL_FB     = 0;
   localparam int unsigned       SL_PD     = 1;
   localparam int unsigned       SL_RA     = 2;

   xdc_seq_e          st_q;
   logic [CNT_W-1:0]  cnt_q;
   logic [CNT_W-1:0]  rd_idx_q;
   logic              rd_vld_q;
   logic [ADDR_W-1:0] ra_q;
   logic [PD_W-1:0]   dest_q;
   logic [ADDR_W-1:0] sp_q;
   logic [ADDR_W-1:0] tgt_q;
   logic [ADDR_W-1:0] slot_q [REC_WORDS];

   logic stack_empty, stack_full, ret_bad;
   assign stack_empty = (tos_q >= STACK_BASE);
   assign stack_full  = (tos_q < FULL_MARK);
   assign ret_bad     = (slot_q[SL_RA] != tgt_q);

   assign busy    = (st_q != SQ_IDLE);
   assign mem_req = (st_q == SQ_PUSH) || (st_q == SQ_POP);
   assign mem_we  = (st_q == SQ_PUSH);

   always_comb begin
      mem_addr  = tos_q + (ADDR_W'(cnt_q) * STEP);
      mem_wdata = '0;
      if (st_q == SQ_PUSH) begin
         mem_addr = tos_q - ((ADDR_W'(cnt_q) + 1'b1) * STEP);
         case (cnt_q)
            CNT_W'(0): mem_wdata = ra_q;
            CNT_W'(1): mem_wdata = ADDR_W'(pd_q);
            default:   mem_wdata = fb_q;
         endcase
      end
   end

   always_comb begin
      commit  = 1'b0;
      new_pd  = dest_q;
      new_fb  = sp_q;
      new_tos = tos_q - REC_BYTES;
      if (st_q == SQ_PUSH && cnt_q == LAST) begin
         commit = 1'b1;
      end else if (st_q == SQ_CHECK && !ret_bad) begin
         commit  = 1'b1;
         new_pd  = slot_q[SL_PD][PD_W-1:0];
         new_fb  = slot_q[SL_FB];
         new_tos = tos_q + REC_BYTES;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_vld_q <= 1'b0;
         rd_idx_q <= '0;
         for (int i = 0; i < int'(REC_WORDS); i++) slot_q[i] <= '0;
      end else begin
         rd_vld_q <= mem_req && !mem_we;
         rd_idx_q <= cnt_q;
         for (int i = 0; i < int'(REC_WORDS); i++)
            if (rd_vld_q && rd_idx_q == CNT_W'(i)) slot_q[i] <= mem_rdata;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q    <= SQ_IDLE;
         cnt_q   <= '0;
         ra_q    <= '0;
         dest_q  <= '0;
         sp_q    <= '0;
         tgt_q   <= '0;
         done_q  <= 1'b0;
         fault_q <= 1'b0;
         code_q  <= XF_NONE;
      end else begin
         done_q  <= 1'b0;
         fault_q <= 1'b0;
         code_q  <= XF_NONE;
         case (st_q)
            SQ_IDLE: begin
               cnt_q <= '0;
               if (xcall_req) begin
                  if (stack_full) begin
                     done_q  <= 1'b1;
                     fault_q <= 1'b1;
                     code_q  <= XF_OVERFLOW;
                  end else begin
                     ra_q   <= call_ret_addr;
                     dest_q <= call_dest_pd;
                     sp_q   <= call_sp;
                     st_q   <= SQ_PUSH;
                  end
               end else if (xret_req) begin
                  if (stack_empty) begin
                     done_q  <= 1'b1;
                     fault_q <= 1'b1;
                     code_q  <= XF_EMPTY;
                  end else begin
                     tgt_q <= ret_target;
                     st_q  <= SQ_POP;
                  end
               end
            end
            SQ_PUSH: begin
               if (cnt_q == LAST) begin
                  st_q   <= SQ_IDLE;
                  done_q <= 1'b1;
               end else begin
                  cnt_q <= cnt_q + 1'b1;
               end
            end
            SQ_POP: begin
               if (cnt_q == LAST) st_q <= SQ_WAIT;
               else cnt_q <= cnt_q + 1'b1;
            end
            SQ_WAIT: st_q <= SQ_CHECK;
            SQ_CHECK: begin
               st_q   <= SQ_IDLE;
               done_q <= 1'b1;
               if (ret_bad) begin
                  fault_q <= 1'b1;
                  code_q  <= XF_MISMATCH;
               end
            end
            default: st_q <= SQ_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/xdc_call_unit.sv
module xdc_call_unit
   import xdc_pkg::*;
#(
   parameter int unsigned ADDR_W = 32,
   parameter int unsigned PD_W = 16,
   parameter logic [ADDR_W-1:0] STACK_BASE = 32'h0000_0100,
   parameter logic [ADDR_W-1:0] STACK_LIMIT = 32'h0000_00C0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              xcall_req,
   input  logic [PD_W-1:0]   call_dest_pd,
   input  logic [ADDR_W-1:0] call_ret_addr,
   input  logic [ADDR_W-1:0] call_sp,
   input  logic              xret_req,
   input  logic [ADDR_W-1:0] ret_target,
   input  logic              tos_ld_en,
   input  logic [ADDR_W-1:0] tos_ld_data,
   output logic              mem_req,
   output logic              mem_we,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [ADDR_W-1:0] mem_wdata,
   input  logic [ADDR_W-1:0] mem_rdata,
   output logic              busy,
   output logic              done,
   output logic              fault,
   output logic [1:0]        fault_code,
   output logic [PD_W-1:0]   pd_id,
   output logic [ADDR_W-1:0] frame_base,
   output logic [ADDR_W-1:0] tos,
   output logic              user_mode,
   output logic              all_access
);
   if (ADDR_W != 32) begin : g_bad_width
      $error("ADDR_W must be 32: records are 32-bit words");
   end
   if (PD_W < 2 || PD_W > ADDR_W) begin : g_bad_pd
      $error("PD_W must lie between 2 and ADDR_W");
   end
   if (STACK_BASE <= STACK_LIMIT + ADDR_W'(REC_WORDS * WORD_BYTES)) begin : g_bad_stack
      $error("stack region must hold at least one record");
   end
   if (STACK_BASE[1:0] != 2'b00 || STACK_LIMIT[1:0] != 2'b00) begin : g_bad_align
      $error("stack bounds must be word aligned");
   end

   logic              commit;
   logic [PD_W-1:0]   new_pd;
   logic [ADDR_W-1:0] new_fb;
   logic [ADDR_W-1:0] new_tos;
   xdc_fault_e        code;

   xdc_state #(
      .ADDR_W(ADDR_W), .PD_W(PD_W), .STACK_BASE(STACK_BASE)
   ) u_state (
      .clk(clk), .rst_n(rst_n), .busy(busy),
      .ld_en(tos_ld_en), .ld_data(tos_ld_data),
      .commit(commit), .new_pd(new_pd), .new_fb(new_fb), .new_tos(new_tos),
      .pd_q(pd_id), .fb_q(frame_base), .tos_q(tos)
   );

   xdc_seq #(
      .ADDR_W(ADDR_W), .PD_W(PD_W),
      .STACK_BASE(STACK_BASE), .STACK_LIMIT(STACK_LIMIT)
   ) u_seq (
      .clk(clk), .rst_n(rst_n),
      .xcall_req(xcall_req), .call_dest_pd(call_dest_pd),
      .call_ret_addr(call_ret_addr), .call_sp(call_sp),
      .xret_req(xret_req), .ret_target(ret_target),
      .pd_q(pd_id), .fb_q(frame_base), .tos_q(tos),
      .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
      .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
      .busy(busy), .commit(commit),
      .new_pd(new_pd), .new_fb(new_fb), .new_tos(new_tos),
      .done_q(done), .fault_q(fault), .code_q(code)
   );

   assign fault_code = code;
   assign user_mode  = pd_id[PD_W-1];
   assign all_access = (pd_id == '0);
endmodule

// File: rtl/xdc_call_unit_chk.sv
module xdc_call_unit_chk #(
   parameter int unsigned ADDR_W = 32,
   parameter int unsigned PD_W = 16
) (
   input logic              clk,
   input logic              rst_n,
   input logic              busy,
   input logic              done,
   input logic              fault,
   input logic [1:0]        fault_code,
   input logic              mem_req,
   input logic [PD_W-1:0]   pd_id,
   input logic [ADDR_W-1:0] tos,
   input logic              all_access
);
   a_r8_no_mem_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> !mem_req);

   a_r8_done_ends_busy: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !busy);

   a_r5_fault_has_code: assert property (@(posedge clk) disable iff (!rst_n)
      fault |-> (done && fault_code != 2'd0));

   a_r6_fault_keeps_domain: assert property (@(posedge clk) disable iff (!rst_n)
      fault |-> $stable(pd_id));

   a_r3_domain_moves_on_done: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(pd_id) |-> done);

   a_r9_tos_locked_for_others: assert property (@(posedge clk) disable iff (!rst_n)
      (!all_access && !busy) |=> $stable(tos));
endmodule

bind xdc_call_unit xdc_call_unit_chk #(.ADDR_W(ADDR_W), .PD_W(PD_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .busy(busy), .done(done), .fault(fault),
   .fault_code(fault_code), .mem_req(mem_req), .pd_id(pd_id), .tos(tos),
   .all_access(all_access)
);

// File: tb/tb_xdc_call_unit.sv
`timescale 1ns/1ps
module tb_xdc_call_unit;
   localparam logic [31:0] BASE  = 32'h0000_0100;
   localparam logic [31:0] LIMIT = 32'h0000_00C0;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        xcall_req = 1'b0;
   logic [15:0] call_dest_pd = '0;
   logic [31:0] call_ret_addr = '0;
   logic [31:0] call_sp = '0;
   logic        xret_req = 1'b0;
   logic [31:0] ret_target = '0;
   logic        tos_ld_en = 1'b0;
   logic [31:0] tos_ld_data = '0;
   logic        mem_req, mem_we;
   logic [31:0] mem_addr, mem_wdata;
   logic [31:0] mem_rdata = '0;
   logic        busy, done, fault, user_mode, all_access;
   logic [1:0]  fault_code;
   logic [15:0] pd_id;
   logic [31:0] frame_base, tos;

   int checks = 0;
   int errors = 0;
   int wr_count = 0;
   int rd_count = 0;
   logic [31:0] mem [64];

   always #2.5 clk = ~clk;

   xdc_call_unit #(.STACK_BASE(BASE), .STACK_LIMIT(LIMIT)) dut (
      .clk(clk), .rst_n(rst_n), .xcall_req(xcall_req), .call_dest_pd(call_dest_pd),
      .call_ret_addr(call_ret_addr), .call_sp(call_sp), .xret_req(xret_req),
      .ret_target(ret_target), .tos_ld_en(tos_ld_en), .tos_ld_data(tos_ld_data),
      .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
      .mem_rdata(mem_rdata), .busy(busy), .done(done), .fault(fault),
      .fault_code(fault_code), .pd_id(pd_id), .frame_base(frame_base), .tos(tos),
      .user_mode(user_mode), .all_access(all_access)
   );

   always @(posedge clk) begin
      if (mem_req && mem_we) begin
         mem[mem_addr[7:2]] <= mem_wdata;
         wr_count <= wr_count + 1;
      end
      if (mem_req && !mem_we) rd_count <= rd_count + 1;
      mem_rdata <= mem[mem_addr[7:2]];
   end

   task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic wait_done(output bit f, output logic [1:0] code);
      bit seen = 0;
      f = 0; code = '0;
      for (int i = 0; i < 20 && !seen; i++) begin
         @(negedge clk);
         if (done) begin seen = 1; f = fault; code = fault_code; end
      end
      chk(seen, "R8 done pulse", 32'(seen), 32'd1);
   endtask

   task automatic do_call(input logic [15:0] dpd, input logic [31:0] ra, input logic [31:0] sp,
                          output bit f, output logic [1:0] code);
      @(negedge clk);
      xcall_req = 1; call_dest_pd = dpd; call_ret_addr = ra; call_sp = sp;
      @(negedge clk);
      xcall_req = 0;
      if (done) begin f = fault; code = fault_code; end
      else wait_done(f, code);
   endtask

   task automatic do_ret(input logic [31:0] tgt, output bit f, output logic [1:0] code);
      @(negedge clk);
      xret_req = 1; ret_target = tgt;
      @(negedge clk);
      xret_req = 0;
      if (done) begin f = fault; code = fault_code; end
      else wait_done(f, code);
   endtask

   task automatic t_reset();
      chk(pd_id == 16'd0, "R1 pd", 32'(pd_id), 0);
      chk(tos == BASE, "R1 tos", tos, BASE);
      chk(frame_base == 0 && !busy && !done && !fault, "R1 idle", 32'(busy), 0);
      chk(all_access && !user_mode, "R10 kernel domain 0", 32'(all_access), 1);
   endtask

   task automatic t_tos_load();
      @(negedge clk); tos_ld_en = 1; tos_ld_data = 32'h0000_00F0;
      @(negedge clk); tos_ld_en = 0;
      chk(tos == 32'h0000_00F0, "R9 load in domain 0", tos, 32'h0000_00F0);
      @(negedge clk); tos_ld_en = 1; tos_ld_data = BASE;
      @(negedge clk); tos_ld_en = 0;
      chk(tos == BASE, "R9 restore", tos, BASE);
   endtask

   task automatic t_call_first();
      bit f; logic [1:0] c; int w0;
      w0 = wr_count;
      do_call(16'h0005, 32'h0000_1004, 32'h0000_8000, f, c);
      chk(!f, "R3 no fault", 32'(f), 0);
      chk(pd_id == 16'h0005, "R3 pd", 32'(pd_id), 5);
      chk(frame_base == 32'h0000_8000, "R3 fb", frame_base, 32'h8000);
      chk(tos == BASE - 12, "R2 tos", tos, BASE - 12);
      chk(wr_count - w0 == 3, "R2 write count", 32'(wr_count - w0), 3);
      chk(mem[(BASE - 4) >> 2] == 32'h1004, "R2 ret word", mem[(BASE - 4) >> 2], 32'h1004);
      chk(mem[(BASE - 8) >> 2] == 32'h0, "R2 pd word", mem[(BASE - 8) >> 2], 0);
      chk(mem[(BASE - 12) >> 2] == 32'h0, "R2 fb word", mem[(BASE - 12) >> 2], 0);
      chk(!all_access && !user_mode, "R10 kernel nonzero", 32'(all_access), 0);
   endtask

   task automatic t_call_user_busy();
      bit f; logic [1:0] c;
      @(negedge clk);
      xcall_req = 1; call_dest_pd = 16'h8003; call_ret_addr = 32'h0000_2008; call_sp = 32'h0000_7F00;
      @(negedge clk);
      xcall_req = 0;
      chk(busy, "R8 busy after accept", 32'(busy), 1);
      xret_req = 1; ret_target = 32'h0000_1004;
      @(negedge clk);
      xret_req = 0;
      wait_done(f, c);
      chk(!f && pd_id == 16'h8003, "R8 ret ignored while busy", 32'(pd_id), 32'h8003);
      chk(tos == BASE - 24, "R2 nested tos", tos, BASE - 24);
      chk(mem[(BASE - 20) >> 2] == 32'h5, "R2 nested pd word", mem[(BASE - 20) >> 2], 5);
      chk(mem[(BASE - 24) >> 2] == 32'h8000, "R2 nested fb word", mem[(BASE - 24) >> 2], 32'h8000);
      chk(user_mode && !all_access, "R10 user domain", 32'(user_mode), 1);
      @(negedge clk); tos_ld_en = 1; tos_ld_data = 32'h0000_0040;
      @(negedge clk); tos_ld_en = 0;
      chk(tos == BASE - 24, "R9 load ignored", tos, BASE - 24);
   endtask

   task automatic t_returns();
      bit f; logic [1:0] c;
      do_ret(32'h0000_2000, f, c);
      chk(f && c == 2'd2, "R6 mismatch code", 32'(c), 2);
      chk(pd_id == 16'h8003 && tos == BASE - 24, "R6 state kept", tos, BASE - 24);
      do_ret(32'h0000_2008, f, c);
      chk(!f && pd_id == 16'h0005, "R4 pd restored", 32'(pd_id), 5);
      chk(frame_base == 32'h8000 && tos == BASE - 12, "R4 fb tos", tos, BASE - 12);
      do_ret(32'h0000_1004, f, c);
      chk(!f && pd_id == 16'h0 && frame_base == 0, "R4 back to 0", 32'(pd_id), 0);
      chk(tos == BASE, "R4 tos base", tos, BASE);
   endtask

   task automatic t_empty();
      bit f; logic [1:0] c; int r0;
      r0 = rd_count;
      do_ret(32'h0000_1004, f, c);
      chk(f && c == 2'd1, "R5 empty code", 32'(c), 1);
      chk(rd_count == r0 && tos == BASE && pd_id == 0, "R5 no reads", 32'(rd_count - r0), 0);
   endtask

   task automatic t_overflow();
      bit f; logic [1:0] c; int w0;
      for (int k = 0; k < 5; k++) begin
         do_call(16'(k + 1), 32'h3000 + 32'(k * 4), 32'h6000, f, c);
         chk(!f, "R7 room left", 32'(f), 0);
      end
      chk(tos == BASE - 60, "R7 tos before", tos, BASE - 60);
      w0 = wr_count;
      do_call(16'h0009, 32'h4000, 32'h5000, f, c);
      chk(f && c == 2'd3, "R7 overflow code", 32'(c), 3);
      chk(wr_count == w0 && pd_id == 16'd5 && tos == BASE - 60, "R7 nothing written", 32'(wr_count - w0), 0);
   endtask

   initial begin
      #200000;
      errors++;
      $display("FAIL watchdog expired actual=%0d expected=0", 1);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      for (int i = 0; i < 64; i++) mem[i] = '0;
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      t_reset();
      t_tos_load();
      t_call_first();
      t_call_user_busy();
      t_returns();
      t_empty();
      t_overflow();
      repeat (3) @(negedge clk);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule